// File: doc/BRIEF.md
# Host Bridge Control Register Bank with Hard-Fail Policy

This block is the control and status register file of a PCI host bridge. A processor-side register bus reaches it with 64-bit little-endian data and either 4-byte or 8-byte accesses. The file holds six kinds of register:

- a read-only function class constant;
- a bus-number scratch value taken from a static input;
- an arbitration mask;
- a status/control register;
- a parameterized array of 64-bit window base/mask registers;
- an error configuration register.

An error status location always reads as zero.

Each register occupies one 8-byte slot, and decode ignores the low three address bits. A 32-bit access works on one half of the slot: address bit 2 picks the upper half. A 32-bit write merges into the addressed half and keeps the other half unchanged.

An access to an offset that decodes to nothing follows the hard-fail policy. The policy is selected by one bit of the status/control register. With the bit set, such an access returns a decode error. With the bit clear, a read returns all ones and a write has no effect.

The bus is a single-cycle request/response interface. Each accepted request produces exactly one response on the following cycle, and that response carries read data and an error flag.

Top module: `bridge_csr_bank`

## Requirements
- R1: After reset the arbitration mask, status/control, error configuration and every window register read as zero, and no response is signalled until a request arrives.
- R2: A request presented with `req_valid` high in one cycle yields `rsp_valid` high in exactly the next cycle, and `rsp_valid` is low in every cycle that does not follow a request.
- R3: An 8-byte access (`req_size` = 3) reads or writes the whole 64-bit register, and address bits 2:0 are ignored.
- R4: A 4-byte write (`req_size` = 2) takes `req_wdata[31:0]` and stores it in bits 63:32 when address bit 2 is set, or in bits 31:0 otherwise. The other half is kept.
- R5: A 4-byte read returns the addressed half (bits 63:32 when address bit 2 is set, bits 31:0 otherwise) in `rsp_rdata[31:0]`, with `rsp_rdata[63:32]` zero.
- R6: Offset 0x08 reads as the constant 0x6000005, and writes to it have no effect and raise no error.
- R7: Offset 0x58 reads as the bus number in bits 7:0 and again in bits 15:8, with all other bits zero. Writes to it have no effect and raise no error.
- R8: Offsets 0x200 through 0x248 are ten independent 64-bit window registers, numbered (offset − 0x200)/8.
- R9: Offset 0x688 always reads as zero without error, and writes to it have no effect.
- R10: While bit 3 of the status/control register (offset 0x108) is clear, a read of an unmapped offset returns all ones without error. For a 4-byte read, all ones means 0xFFFFFFFF in bits 31:0. A write to an unmapped offset changes no register.
- R11: While bit 3 of status/control is set, an access to an unmapped offset returns `rsp_err` high with read data zero and changes no register.
- R12: An access with `req_size` of 0 or 1 returns `rsp_err` high with read data zero whatever the hard-fail bit, and changes no register.
- R13: Every write response, and every error response, carries `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_num | input | 8 | Static bus number shown at offset 0x58 |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 13 | Byte offset of the access |
| req_size | input | 2 | log2 of the access size in bytes (2 = 4 bytes, 3 = 8 bytes) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Decode or size error |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench builds the block with its default parameters:

- a 13-bit offset, so the whole 8 KB slot space can be reached;
- ten window registers, so the first and last array slots sit at 0x200 and 0x248 and the next slot, 0x250, is unmapped;
- hard-fail on bit 3.

With the defaults, random offsets land on both mapped and unmapped slots. Random writes to status/control flip the hard-fail policy in mid-run, so both unmapped-access behaviours are exercised against the same register state.

// File: rtl/bridge_csr_pkg.sv
package bridge_csr_pkg;

  // Which register an access decodes to.
  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_CLASS   = 3'd1,
    SEL_BUSNUM  = 3'd2,
    SEL_ARB     = 3'd3,
    SEL_STATCTL = 3'd4,
    SEL_WINDOW  = 3'd5,
    SEL_ERRCFG  = 3'd6,
    SEL_ERRSTAT = 3'd7
  } csr_sel_e;

  typedef struct packed {
    csr_sel_e sel;
    logic     writable;
  } csr_hit_t;

  // Slot offsets (bytes, low three bits zero).
  localparam int unsigned OFS_CLASS   = 32'h0008;
  localparam int unsigned OFS_BUSNUM  = 32'h0058;
  localparam int unsigned OFS_ARB     = 32'h0080;
  localparam int unsigned OFS_STATCTL = 32'h0108;
  localparam int unsigned OFS_WINBASE = 32'h0200;
  localparam int unsigned OFS_ERRCFG  = 32'h0680;
  localparam int unsigned OFS_ERRSTAT = 32'h0688;

  // Access size codes (log2 of byte count).
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [63:0] CLASS_VALUE = 64'h0000_0000_0600_0005;

endpackage

// File: rtl/bridge_csr_decode.sv
module bridge_csr_decode
  import bridge_csr_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int NUM_WIN = 10,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_hit_t          hit,
  output logic [IDX_W-1:0]  win_idx
);

  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(OFS_WINBASE);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(OFS_WINBASE + 8 * NUM_WIN);

  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] win_delta;
  logic              in_win;

  always_comb begin
    slot      = {addr[ADDR_W-1:3], 3'b000};
    win_delta = slot - WIN_LO;
    in_win    = (slot >= WIN_LO) && (slot < WIN_END);
    win_idx   = win_delta[IDX_W+2:3];
  end

  always_comb begin
    hit.sel      = SEL_NONE;
    hit.writable = 1'b0;
    if (in_win) begin
      hit.sel      = SEL_WINDOW;
      hit.writable = 1'b1;
    end else begin
      case (slot)
        ADDR_W'(OFS_CLASS):   hit.sel = SEL_CLASS;
        ADDR_W'(OFS_BUSNUM):  hit.sel = SEL_BUSNUM;
        ADDR_W'(OFS_ARB): begin
          hit.sel      = SEL_ARB;
          hit.writable = 1'b1;
        end
        ADDR_W'(OFS_STATCTL): begin
          hit.sel      = SEL_STATCTL;
          hit.writable = 1'b1;
        end
        ADDR_W'(OFS_ERRCFG): begin
          hit.sel      = SEL_ERRCFG;
          hit.writable = 1'b1;
        end
        ADDR_W'(OFS_ERRSTAT): hit.sel = SEL_ERRSTAT;
        default:              hit.sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bridge_csr_merge.sv
// Builds the post-write value of a 64-bit slot from its old value.
module bridge_csr_merge
  import bridge_csr_pkg::*;
(
  input  logic [63:0] old_val,
  input  logic [63:0] wdata,
  input  logic [1:0]  size,
  input  logic        upper,
  output logic [63:0] new_val
);

  always_comb begin
    if (size == SZ_DWORD) begin
      new_val = wdata;
    end else if (upper) begin
      new_val = {wdata[31:0], old_val[31:0]};
    end else begin
      new_val = {old_val[63:32], wdata[31:0]};
    end
  end

endmodule

// File: rtl/bridge_csr_rdsel.sv
// Narrows a 64-bit slot value to the width of the read.
module bridge_csr_rdsel
  import bridge_csr_pkg::*;
(
  input  logic [63:0] full_val,
  input  logic [1:0]  size,
  input  logic        upper,
  output logic [63:0] out_val
);

  always_comb begin
    if (size == SZ_DWORD) begin
      out_val = full_val;
    end else if (upper) begin
      out_val = {32'h0, full_val[63:32]};
    end else begin
      out_val = {32'h0, full_val[31:0]};
    end
  end

endmodule

// File: rtl/bridge_csr_bank.sv
module bridge_csr_bank
  import bridge_csr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NUM_WIN = 10,
  parameter int BUS_W = 8,
  parameter int HF_BIT = 3,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_num,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  // Decode
  csr_hit_t         hit;
  logic [IDX_W-1:0] win_idx;

  bridge_csr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_WIN (NUM_WIN)
  ) decode_i (
    .addr    (req_addr),
    .hit     (hit),
    .win_idx (win_idx)
  );

  // Register state
  logic [63:0] arb_q, stat_q, ecfg_q;
  logic [63:0] win_q [NUM_WIN];

  logic        size_ok;
  logic        mapped;
  logic        hf_en;
  logic        acc_err;
  logic        wr_ok;
  logic        upper;

  always_comb begin
    size_ok = (req_size == SZ_WORD) || (req_size == SZ_DWORD);
    mapped  = (hit.sel != SEL_NONE);
    hf_en   = stat_q[HF_BIT];
    upper   = req_addr[2];
    acc_err = !size_ok || (!mapped && hf_en);
    wr_ok   = req_valid && req_write && size_ok && hit.writable;
  end

  // Selected current value, shared by read path and write merge
  logic [63:0] cur_val;

  always_comb begin
    case (hit.sel)
      SEL_CLASS:   cur_val = CLASS_VALUE;
      SEL_BUSNUM:  cur_val = {{(64 - 2 * BUS_W){1'b0}}, bus_num, bus_num};
      SEL_ARB:     cur_val = arb_q;
      SEL_STATCTL: cur_val = stat_q;
      SEL_WINDOW:  cur_val = win_q[win_idx];
      SEL_ERRCFG:  cur_val = ecfg_q;
      SEL_ERRSTAT: cur_val = 64'h0;
      default:     cur_val = {64{1'b1}};
    endcase
  end

  logic [63:0] merged_val;

  bridge_csr_merge merge_i (
    .old_val (cur_val),
    .wdata   (req_wdata),
    .size    (req_size),
    .upper   (upper),
    .new_val (merged_val)
  );

  logic [63:0] narrow_val;

  bridge_csr_rdsel rdsel_i (
    .full_val (cur_val),
    .size     (req_size),
    .upper    (upper),
    .out_val  (narrow_val)
  );

  // Per-register write enables
  logic arb_en, stat_en, ecfg_en;
  logic [NUM_WIN-1:0] win_en;

  always_comb begin
    arb_en  = wr_ok && (hit.sel == SEL_ARB);
    stat_en = wr_ok && (hit.sel == SEL_STATCTL);
    ecfg_en = wr_ok && (hit.sel == SEL_ERRCFG);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      arb_q <= 64'h0;
    end else if (arb_en) begin
      arb_q <= merged_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      stat_q <= 64'h0;
    end else if (stat_en) begin
      stat_q <= merged_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ecfg_q <= 64'h0;
    end else if (ecfg_en) begin
      ecfg_q <= merged_val;
    end
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    always_comb begin
      win_en[gi] = wr_ok && (hit.sel == SEL_WINDOW) && (win_idx == IDX_W'(gi));
    end

    always_ff @(posedge clk or negedge rst_n_sync) begin
      if (!rst_n_sync) begin
        win_q[gi] <= 64'h0;
      end else if (win_en[gi]) begin
        win_q[gi] <= merged_val;
      end
    end
  end

  // Response
  logic        rsp_valid_d;
  logic        rsp_err_d;
  logic [63:0] rsp_rdata_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = req_valid && acc_err;
    if (!req_valid || acc_err || req_write) begin
      rsp_rdata_d = 64'h0;
    end else begin
      rsp_rdata_d = narrow_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 64'h0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/bridge_csr_checker.sv
module bridge_csr_checker
  import bridge_csr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [63:0]       rsp_rdata
);

  logic is_rd_class, is_rd_errstat, bad_size;

  always_comb begin
    is_rd_class   = req_valid && !req_write &&
                    ({req_addr[ADDR_W-1:3], 3'b000} == ADDR_W'(OFS_CLASS));
    is_rd_errstat = req_valid && !req_write &&
                    ({req_addr[ADDR_W-1:3], 3'b000} == ADDR_W'(OFS_ERRSTAT));
    bad_size      = (req_size != SZ_WORD) && (req_size != SZ_DWORD);
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == SZ_WORD) |=> (rsp_rdata[63:32] == 32'h0));

  assert_class_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd_class && req_size == SZ_DWORD) |=> (rsp_rdata == CLASS_VALUE && !rsp_err));

  assert_errstat_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd_errstat && !bad_size) |=> (rsp_rdata == 64'h0 && !rsp_err));

  assert_bad_size_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_size) |=> rsp_err);

  assert_err_zero_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 64'h0));

endmodule

bind bridge_csr_bank bridge_csr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/bridge_csr_bank_tb.sv
module bridge_csr_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int NWIN = 10;
  localparam logic [7:0] BUSN = 8'h5A;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [63:0]       req_wdata;
  logic              rsp_valid;
  logic              rsp_err;
  logic [63:0]       rsp_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bridge_csr_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_num   (BUSN),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  logic [63:0] m_arb, m_stat, m_ecfg;
  logic [63:0] m_win [NWIN];

  // 0 none,1 class,2 bus,3 arb,4 stat,5 win,6 ecfg,7 estat
  function automatic int kind_of(input logic [ADDR_W-1:0] a);
    int s;
    s = int'(a) & ~7;
    if (s >= 'h200 && s < 'h200 + 8 * NWIN) return 5;
    if (s == 'h008) return 1;
    if (s == 'h058) return 2;
    if (s == 'h080) return 3;
    if (s == 'h108) return 4;
    if (s == 'h680) return 6;
    if (s == 'h688) return 7;
    return 0;
  endfunction

  function automatic logic [63:0] model_full(input logic [ADDR_W-1:0] a);
    case (kind_of(a))
      1: return 64'h6000005;
      2: return {48'h0, BUSN, BUSN};
      3: return m_arb;
      4: return m_stat;
      5: return m_win[(int'(a) - 'h200) / 8];
      6: return m_ecfg;
      7: return 64'h0;
      default: return {64{1'b1}};
    endcase
  endfunction

  function automatic logic [63:0] narrow(input logic [63:0] v, input logic [1:0] sz,
                                         input logic up);
    if (sz == 2'd3) return v;
    return up ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] w,
                                        input logic [1:0] sz, input logic up);
    if (sz == 2'd3) return w;
    return up ? {w[31:0], o[31:0]} : {o[63:32], w[31:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, check the response one cycle later.
  task automatic access(input string req, input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [1:0] sz, input logic [63:0] wd);
    int k;
    logic szok, eerr;
    logic [63:0] edata;
    k = kind_of(a);
    szok = (sz == 2'd2) || (sz == 2'd3);
    eerr = !szok || (k == 0 && m_stat[3]);
    edata = (eerr || wr) ? 64'h0 : narrow(model_full(a), sz, a[2]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {63'h0, rsp_valid}, 64'h1);
    check({req, " err"}, {63'h0, rsp_err}, {63'h0, eerr});
    check({req, " data"}, rsp_rdata, edata);
    if (wr && szok) begin
      case (k)
        3: m_arb  = merge(m_arb, wd, sz, a[2]);
        4: m_stat = merge(m_stat, wd, sz, a[2]);
        5: m_win[(int'(a) - 'h200) / 8] = merge(m_win[(int'(a) - 'h200) / 8], wd, sz, a[2]);
        6: m_ecfg = merge(m_ecfg, wd, sz, a[2]);
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_arb = 0; m_stat = 0; m_ecfg = 0;
    for (int i = 0; i < NWIN; i++) m_win[i] = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 3; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state, no response while idle
    check("R1 idle rsp_valid", {63'h0, rsp_valid}, 64'h0);
    access("R1 arb reset", 0, 'h080, 3, 0);
    access("R1 stat reset", 0, 'h108, 3, 0);
    access("R1 ecfg reset", 0, 'h680, 3, 0);
    for (int i = 0; i < NWIN; i++) access("R1 win reset", 0, ADDR_W'('h200 + 8 * i), 3, 0);
    @(negedge clk);
    check("R2 no rsp after idle", {63'h0, rsp_valid}, 64'h0);

    // R6 / R7 constants, and writes ignored
    access("R6 class 64", 0, 'h008, 3, 0);
    access("R6 class 32 low", 0, 'h008, 2, 0);
    access("R6 class 32 high", 0, 'h00C, 2, 0);
    access("R6 class write", 1, 'h008, 3, 64'hDEAD);
    access("R6 class after write", 0, 'h008, 3, 0);
    access("R7 busnum", 0, 'h058, 3, 0);
    access("R7 busnum write", 1, 'h05C, 2, 64'hFFFF_FFFF);
    access("R7 busnum after write", 0, 'h058, 3, 0);

    // R3 / R8 windows: full writes, distinct values, edge slots
    for (int i = 0; i < NWIN; i++)
      access("R8 win write", 1, ADDR_W'('h200 + 8 * i), 3, {32'hA5A5_0000 + 32'(i), 32'h1111_0000 + 32'(i)});
    for (int i = 0; i < NWIN; i++) access("R8 win read", 0, ADDR_W'('h200 + 8 * i), 3, 0);
    access("R3 low bits ignored", 0, 'h24F & ~13'h4 | 13'h3, 3, 0);

    // R4 / R5 half merge and select
    access("R4 arb full", 1, 'h080, 3, 64'h0123_4567_89AB_CDEF);
    access("R4 arb upper half", 1, 'h084, 2, 64'hFFFF_FFFF_CAFE_F00D);
    access("R4 arb after upper", 0, 'h080, 3, 0);
    access("R4 arb lower half", 1, 'h081, 2, 64'h0000_0000_1234_5678);
    access("R4 arb after lower", 0, 'h080, 3, 0);
    access("R5 arb read high", 0, 'h084, 2, 0);
    access("R5 arb read low", 0, 'h080, 2, 0);

    // R9 error status
    access("R9 estat", 0, 'h688, 3, 0);
    access("R9 estat write", 1, 'h688, 3, 64'hFF);
    access("R9 estat after write", 0, 'h68C, 2, 0);

    // R10 unmapped, hard-fail clear
    access("R10 unmapped read 64", 0, 'h000, 3, 0);
    access("R10 unmapped read 32", 0, 'h254, 2, 0);
    access("R10 unmapped write", 1, 'h250, 3, 64'h55);
    access("R10 last window untouched", 0, 'h248, 3, 0);

    // R11 unmapped, hard-fail set
    access("R11 set hf", 1, 'h108, 2, 64'h8);
    access("R11 unmapped read", 0, 'h040, 3, 0);
    access("R11 unmapped write", 1, 'h1F8, 3, 64'h77);
    access("R11 mapped still ok", 0, 'h080, 3, 0);

    // R12 invalid sizes, either policy
    access("R12 size0 write", 1, 'h080, 0, 64'h9);
    access("R12 size1 read", 0, 'h080, 1, 0);
    access("R12 arb unchanged", 0, 'h080, 3, 0);
    access("R12 clear hf", 1, 'h108, 3, 64'h0);
    access("R12 size1 unmapped no hf", 0, 'h000, 1, 0);

    // R13 and mixed: random traffic
    for (int n = 0; n < 600; n++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0] sz;
      int pick;
      pick = int'($urandom % 8);
      case (pick)
        0: a = 'h080;
        1: a = 'h108;
        2: a = 'h680;
        3, 4: a = ADDR_W'('h200 + 8 * ($urandom % NWIN));
        5: a = 'h008;
        default: a = ADDR_W'($urandom);
      endcase
      a = {a[ADDR_W-1:3], 3'($urandom)};
      sz = ($urandom % 10 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
      access("R13 random", 1'($urandom), a, sz, {$urandom, $urandom});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule